// File: doc/BRIEF.md
# Soft-Switch Floppy Controller Register File

This block is the host-facing register file of a floppy disk controller. The host never writes a conventional address decode. Instead, each access to one of sixteen locations sets or clears one of eight state latches. Address bits 3:1 pick the latch and address bit 0 gives its new value. The combination of the latches then decides what a read returns and where a write goes. The bit-serial read path, the motor-off timer and the drive mechanics sit outside the block. They appear only as a data-byte load input, a motor-on input, a set of drive-condition inputs, a write-data strobe and a command strobe.

The read side works as a small state machine over the two latches named Q6 and Q7. The four read-select states are:
- DATA, with both latches clear.
- STATUS, with Q6 set and Q7 clear.
- HANDSHAKE, with Q7 set and Q6 clear.
- BLANK, with both set.

An access moves between these states when it sets or clears Q6 or Q7 (the SET_Q6, CLR_Q6, SET_Q7 and CLR_Q7 transitions). Accesses to the other six latches leave the read-select state unchanged.

Every access is applied first. Its read or write is then served from the updated latch state. Read data appears one cycle after the access, together with a valid pulse. A falling edge of the strobe latch (LSTRB) issues a one-cycle drive command.

Top module: `flopctl_regs`

## Requirements
- R1: An access (read or write) with address `a` sets latch `a[3:1]` to `a[0]`, on the clock edge that samples the access. The latch order by index is 0 CA0, 1 CA1, 2 CA2, 3 LSTRB, 4 ENABLE, 5 DRIVESEL, 6 Q6, 7 Q7. ENABLE and DRIVESEL are visible on `enable_out` and `drvsel_out`. All other latches stay unchanged.
- R2: An even-address read that leaves Q6 and Q7 both clear returns the data register on `rdata`, with `rdata_valid` high, in the cycle after the access. If bit 7 of the returned byte is 1, the data register becomes 0x00 after the read; otherwise it keeps its value.
- R3: An even-address read that leaves Q6 set and Q7 clear returns status. Bits 4:0 are mode bits 4:0, bit 5 equals `motor_on_in`, and bit 6 is 0.
- R4: Status bit 7 is a sense value selected by the 4-bit code {CA2,CA1,CA0,SEL}, where SEL is `sel_in`. The codes are:
  - 0001: not `cond_disk_in`.
  - 0011: `cond_wprot`.
  - 0100: not `cond_motor_run`.
  - 0101: not `cond_track0`.
  - 0111: not `cond_tach`.
  - 1100: `cond_one_side`.
  - 1110 and 1111: not `cond_present`.
  - Every other code: 0.
- R5: An even-address read that leaves Q7 set and Q6 clear returns the handshake register, 0xFF.
- R6: A read at any odd address returns 0xFF. An even-address read that leaves Q6 and Q7 both set also returns 0xFF.
- R7: A write that leaves Q7 and Q6 set and ENABLE clear loads all 8 bits of `wdata` into the mode register, `mode_out`.
- R8: A write that leaves Q7, Q6 and ENABLE all set pulses `wr_data_stb` for one cycle with `wdata` on `wr_data_out`, and leaves the mode register unchanged.
- R9: Writes in any other latch state, and all reads, leave the mode register unchanged.
- R10: An access that changes LSTRB from 1 to 0 pulses `cmd_stb` for one cycle, with `cmd_code` set by {CA1,CA0,SEL} after the access:
  - 000 gives code 0 (step direction), and `step_dir` takes CA2.
  - 010 gives code 1 (step).
  - 100 gives code 2 (motor on).
  - 110 gives code 3 (eject).
- R11: No command is issued when LSTRB rises, when an access to LSTRB leaves it unchanged, or when a falling edge meets any other {CA1,CA0,SEL} code.
- R12: While `rst` is high at a clock edge, all latches, the mode, data and write-data registers, `step_dir` and all strobes become 0.
- R13: `dreg_load` loads `dreg_in` into the data register. A load in the same cycle as a clearing read wins: the read returns the old byte, and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Host access this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 4 | Access location; bits 3:1 pick the latch, bit 0 is its new value |
| wdata | input | 8 | Write data |
| sel_in | input | 1 | External select bit used in sense and command decode |
| motor_on_in | input | 1 | Motor-on state from the external timer |
| dreg_load | input | 1 | Load a byte from the serial read path |
| dreg_in | input | 8 | Byte from the serial read path |
| cond_disk_in | input | 1 | Disk is inserted |
| cond_wprot | input | 1 | Disk is write protected |
| cond_motor_run | input | 1 | Spindle is turning |
| cond_track0 | input | 1 | Head is at track zero |
| cond_tach | input | 1 | Tachometer level |
| cond_one_side | input | 1 | Drive has one head |
| cond_present | input | 1 | Drive is connected |
| rdata | output | 8 | Read result, one cycle after the access |
| rdata_valid | output | 1 | One-cycle pulse qualifying `rdata` |
| mode_out | output | 8 | Mode register |
| wr_data_stb | output | 1 | One-cycle write-data pulse |
| wr_data_out | output | 8 | Last byte written to the write-data register |
| enable_out | output | 1 | ENABLE latch |
| drvsel_out | output | 1 | DRIVESEL latch |
| cmd_stb | output | 1 | One-cycle drive command pulse |
| cmd_code | output | 2 | Command code qualified by `cmd_stb` |
| step_dir | output | 1 | Held step direction |

## Verification
The status path is swept over all sixteen {CA2,CA1,CA0,SEL} codes under three condition patterns: all conditions true, all false, and alternating. Together these separate the inverted lines from the direct ones and expose any code wired to the wrong condition.

The data register is read with bytes that have bit 7 clear, bit 7 set, and bit 7 set with a same-cycle load. This distinguishes keeping, clearing and load priority.

The writes are arranged so that the mode register is reached only when ENABLE is clear. A write with ENABLE set, a write with Q6 clear and a plain read each show the mode held.

The LSTRB sequence walks the four command codes, one unlisted code, a rising edge and a repeated clear. This shows that only true falling edges with a known code produce a pulse.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int MODE_COPY_W = 5;

    localparam int L_CA0   = 0;
    localparam int L_CA1   = 1;
    localparam int L_CA2   = 2;
    localparam int L_LSTRB = 3;
    localparam int L_EN    = 4;
    localparam int L_DSEL  = 5;
    localparam int L_Q6    = 6;
    localparam int L_Q7    = 7;

    typedef enum logic [1:0] {
        RSEL_DATA   = 2'b00,
        RSEL_STATUS = 2'b01,
        RSEL_HSHK   = 2'b10,
        RSEL_BLANK  = 2'b11
    } rsel_e;

    typedef enum logic [1:0] {
        CMD_DIR   = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_MOTOR = 2'd2,
        CMD_EJECT = 2'd3
    } cmd_e;

    typedef struct packed {
        logic disk_in;
        logic wprot;
        logic motor_run;
        logic track0;
        logic tach;
        logic one_side;
        logic present;
    } drv_cond_t;

endpackage

// File: rtl/fcr_latch_file.sv
module fcr_latch_file #(
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         acc_valid,
    input  logic [ADDR_W-1:0]            acc_addr,
    output logic [(1 << (ADDR_W-1))-1:0] latch_q,
    output logic [(1 << (ADDR_W-1))-1:0] latch_nx
);
    localparam int IDX_W     = ADDR_W - 1;
    localparam int NUM_LATCH = 1 << IDX_W;

    // One flag per latch: the access targets it this cycle.
    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_lat
        logic hit;
        assign hit         = acc_valid && (acc_addr[ADDR_W-1:1] == IDX_W'(i));
        assign latch_nx[i] = hit ? acc_addr[0] : latch_q[i];

        always_ff @(posedge clk) begin
            if (rst) latch_q[i] <= 1'b0;
            else     latch_q[i] <= latch_nx[i];
        end
    end

endmodule

// File: rtl/fcr_sense_mux.sv
module fcr_sense_mux
    import fcr_pkg::*;
(
    input  logic [3:0] code,   // {CA2,CA1,CA0,SEL}
    input  drv_cond_t  cond,
    output logic       sense
);
    always_comb begin
        unique case (code)
            4'b0001: sense = ~cond.disk_in;
            4'b0011: sense =  cond.wprot;
            4'b0100: sense = ~cond.motor_run;
            4'b0101: sense = ~cond.track0;
            4'b0111: sense = ~cond.tach;
            4'b1100: sense =  cond.one_side;
            4'b1110,
            4'b1111: sense = ~cond.present;
            default: sense = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcr_strobe_cmd.sv
module fcr_strobe_cmd
    import fcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lstrb_q,   // latch before the access
    input  logic       lstrb_nx,  // latch after the access
    input  logic       ca0_nx,
    input  logic       ca1_nx,
    input  logic       ca2_nx,
    input  logic       sel_in,
    output logic       cmd_stb,
    output logic [1:0] cmd_code,
    output logic       step_dir
);
    logic fall;
    logic known;
    cmd_e cmd_nx;

    assign fall = lstrb_q && !lstrb_nx;

    always_comb begin
        known  = 1'b1;
        cmd_nx = CMD_DIR;
        unique case ({ca1_nx, ca0_nx, sel_in})
            3'b000:  cmd_nx = CMD_DIR;
            3'b010:  cmd_nx = CMD_STEP;
            3'b100:  cmd_nx = CMD_MOTOR;
            3'b110:  cmd_nx = CMD_EJECT;
            default: known  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_stb  <= 1'b0;
            cmd_code <= 2'd0;
            step_dir <= 1'b0;
        end else begin
            cmd_stb <= fall && known;
            if (fall && known) begin
                cmd_code <= cmd_nx;
                if (cmd_nx == CMD_DIR) step_dir <= ca2_nx;
            end
        end
    end

endmodule

// File: rtl/flopctl_regs.sv
module flopctl_regs
    import fcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [3:0]  acc_addr,
    input  logic [7:0]  wdata,
    input  logic        sel_in,
    input  logic        motor_on_in,
    input  logic        dreg_load,
    input  logic [7:0]  dreg_in,
    input  logic        cond_disk_in,
    input  logic        cond_wprot,
    input  logic        cond_motor_run,
    input  logic        cond_track0,
    input  logic        cond_tach,
    input  logic        cond_one_side,
    input  logic        cond_present,
    output logic [7:0]  rdata,
    output logic        rdata_valid,
    output logic [7:0]  mode_out,
    output logic        wr_data_stb,
    output logic [7:0]  wr_data_out,
    output logic        enable_out,
    output logic        drvsel_out,
    output logic        cmd_stb,
    output logic [1:0]  cmd_code,
    output logic        step_dir
);
    localparam int NUM_LATCH = 1 << (ADDR_W - 1);

    logic [NUM_LATCH-1:0] latch_q;
    logic [NUM_LATCH-1:0] latch_nx;
    rsel_e                rsel;
    drv_cond_t            cond;
    logic                 sense;
    logic [DATA_W-1:0]    status;
    logic [DATA_W-1:0]    read_val;
    logic [DATA_W-1:0]    dreg_q;
    logic [DATA_W-1:0]    mode_q;
    logic                 rd_acc;
    logic                 wr_acc;
    logic                 data_read;

    // State register: the eight soft-switch latches.
    fcr_latch_file #(.ADDR_W(ADDR_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .latch_q   (latch_q),
        .latch_nx  (latch_nx)
    );

    // Read-select state after this access.
    always_comb begin
        unique case ({latch_nx[L_Q7], latch_nx[L_Q6]})
            2'b00: rsel = RSEL_DATA;
            2'b01: rsel = RSEL_STATUS;
            2'b10: rsel = RSEL_HSHK;
            2'b11: rsel = RSEL_BLANK;
        endcase
    end

    assign cond = '{disk_in:   cond_disk_in,
                    wprot:     cond_wprot,
                    motor_run: cond_motor_run,
                    track0:    cond_track0,
                    tach:      cond_tach,
                    one_side:  cond_one_side,
                    present:   cond_present};

    fcr_sense_mux u_sense (
        .code  ({latch_nx[L_CA2], latch_nx[L_CA1], latch_nx[L_CA0], sel_in}),
        .cond  (cond),
        .sense (sense)
    );

    fcr_strobe_cmd u_cmd (
        .clk      (clk),
        .rst      (rst),
        .lstrb_q  (latch_q[L_LSTRB] & acc_valid),
        .lstrb_nx (latch_nx[L_LSTRB]),
        .ca0_nx   (latch_nx[L_CA0]),
        .ca1_nx   (latch_nx[L_CA1]),
        .ca2_nx   (latch_nx[L_CA2]),
        .sel_in   (sel_in),
        .cmd_stb  (cmd_stb),
        .cmd_code (cmd_code),
        .step_dir (step_dir)
    );

    assign status = {sense, 1'b0, motor_on_in, mode_q[MODE_COPY_W-1:0]};

    always_comb begin
        read_val = '1;
        if (!acc_addr[0]) begin
            unique case (rsel)
                RSEL_DATA:   read_val = dreg_q;
                RSEL_STATUS: read_val = status;
                RSEL_HSHK:   read_val = '1;
                RSEL_BLANK:  read_val = '1;
            endcase
        end
    end

    assign rd_acc    = acc_valid && !acc_write;
    assign wr_acc    = acc_valid &&  acc_write;
    assign data_read = rd_acc && !acc_addr[0] && (rsel == RSEL_DATA);

    // Output and register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
            mode_q      <= '0;
            dreg_q      <= '0;
            wr_data_stb <= 1'b0;
            wr_data_out <= '0;
        end else begin
            rdata_valid <= rd_acc;
            if (rd_acc) rdata <= read_val;

            if (dreg_load)                    dreg_q <= dreg_in;
            else if (data_read && dreg_q[7])  dreg_q <= '0;

            wr_data_stb <= 1'b0;
            if (wr_acc && rsel == RSEL_BLANK) begin
                if (latch_nx[L_EN]) begin
                    wr_data_stb <= 1'b1;
                    wr_data_out <= wdata;
                end else begin
                    mode_q <= wdata;
                end
            end
        end
    end

    assign mode_out   = mode_q;
    assign enable_out = latch_q[L_EN];
    assign drvsel_out = latch_q[L_DSEL];

endmodule

// File: rtl/fcr_regs_chk.sv
module fcr_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic       acc_write,
    input logic [3:0] acc_addr,
    input logic [7:0] latch_q,
    input logic [7:0] latch_nx,
    input logic [7:0] rdata,
    input logic       rdata_valid,
    input logic [7:0] mode_out,
    input logic       wr_data_stb,
    input logic       cmd_stb
);
    AST_LATCH_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid) |=> (latch_q[$past(acc_addr[3:1])] == $past(acc_addr[0]))); // R1

    AST_ODD_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr[0]) |=> (rdata == 8'hFF)); // R6

    AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !acc_addr[0] && latch_nx[6] && !latch_nx[7])
        |=> (rdata[6] == 1'b0 && rdata[4:0] == mode_out[4:0])); // R3

    AST_CMD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> ($past(latch_q[3]) && !latch_q[3])); // R10

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write) |=> $stable(mode_out)); // R9

    AST_WSTB_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        wr_data_stb |-> $stable(mode_out)); // R8

    AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> $past(acc_valid && !acc_write)); // R2

endmodule

bind flopctl_regs fcr_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .latch_q     (latch_q),
    .latch_nx    (latch_nx),
    .rdata       (rdata),
    .rdata_valid (rdata_valid),
    .mode_out    (mode_out),
    .wr_data_stb (wr_data_stb),
    .cmd_stb     (cmd_stb)
);

// File: tb/tb_flopctl_regs.sv
`timescale 1ns/1ps
module tb_flopctl_regs;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 0, acc_write = 0;
    logic [3:0] acc_addr = '0;
    logic [7:0] wdata = '0;
    logic sel_in = 0, motor_on_in = 0, dreg_load = 0;
    logic [7:0] dreg_in = '0;
    logic c_disk = 0, c_wprot = 0, c_mot = 0, c_trk0 = 0, c_tach = 0, c_one = 0, c_pres = 0;
    logic [7:0] rdata, mode_out, wr_data_out;
    logic rdata_valid, wr_data_stb, enable_out, drvsel_out, cmd_stb, step_dir;
    logic [1:0] cmd_code;

    always #2.5 clk = ~clk;

    flopctl_regs dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .wdata(wdata), .sel_in(sel_in), .motor_on_in(motor_on_in),
        .dreg_load(dreg_load), .dreg_in(dreg_in),
        .cond_disk_in(c_disk), .cond_wprot(c_wprot), .cond_motor_run(c_mot),
        .cond_track0(c_trk0), .cond_tach(c_tach), .cond_one_side(c_one),
        .cond_present(c_pres),
        .rdata(rdata), .rdata_valid(rdata_valid), .mode_out(mode_out),
        .wr_data_stb(wr_data_stb), .wr_data_out(wr_data_out),
        .enable_out(enable_out), .drvsel_out(drvsel_out),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code), .step_dir(step_dir)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] rq_exp[$];
    string      rq_tag[$];
    logic [1:0] cq_exp[$];

    logic [7:0] lat = '0;      // bench view of the latches
    logic [7:0] mode_m = '0;   // bench view of the mode register

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic s;
        case ({lat[2], lat[1], lat[0], sel_in})
            4'b0001: s = !c_disk;
            4'b0011: s = c_wprot;
            4'b0100: s = !c_mot;
            4'b0101: s = !c_trk0;
            4'b0111: s = !c_tach;
            4'b1100: s = c_one;
            4'b1110: s = !c_pres;
            4'b1111: s = !c_pres;
            default: s = 1'b0;
        endcase
        return {s, 1'b0, motor_on_in, mode_m[4:0]};
    endfunction

    // kind: 0 = no read check, 1 = explicit expected, 2 = expected from status model
    task automatic acc(input bit wr, input logic [3:0] a, input logic [7:0] d,
                       input int kind, input logic [7:0] exp, input string tag,
                       input bit ld = 0, input logic [7:0] ldv = 8'h00);
        logic old_lstrb;
        logic [7:0] e;
        old_lstrb = lat[3];
        lat[a[3:1]] = a[0];
        if (old_lstrb && !lat[3]) begin
            case ({lat[1], lat[0], sel_in})
                3'b000: cq_exp.push_back(2'd0);
                3'b010: cq_exp.push_back(2'd1);
                3'b100: cq_exp.push_back(2'd2);
                3'b110: cq_exp.push_back(2'd3);
                default: ;
            endcase
        end
        if (wr && lat[7] && lat[6] && !lat[4]) mode_m = d;
        if (!wr) begin
            e = (kind == 2) ? exp_status() : exp;
            rq_exp.push_back(e);
            rq_tag.push_back(tag);
        end
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_addr = a; wdata = d;
        dreg_load = ld; dreg_in = ldv;
        @(negedge clk);
        acc_valid = 0; acc_write = 0; dreg_load = 0;
    endtask

    task automatic load_byte(input logic [7:0] v);
        @(negedge clk);
        dreg_load = 1; dreg_in = v;
        @(negedge clk);
        dreg_load = 0;
    endtask

    // Monitor: compares read results and command pulses with the queues.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rdata_valid) begin
                if (rq_exp.size() == 0) check(1'b0, "R2 unexpected read", rdata, 8'h00);
                else begin
                    logic [7:0] e;
                    string t;
                    e = rq_exp.pop_front();
                    t = rq_tag.pop_front();
                    check(rdata === e, t, rdata, e);
                end
            end
            if (!rst && cmd_stb) begin
                if (cq_exp.size() == 0) check(1'b0, "R11 unexpected command", {6'd0, cmd_code}, 8'h00);
                else begin
                    logic [1:0] c;
                    c = cq_exp.pop_front();
                    check(cmd_code === c, "R10 command code", {6'd0, cmd_code}, {6'd0, c});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R12 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(mode_out === 8'h00, "R12 mode after reset", mode_out, 8'h00);
        check({rdata_valid, cmd_stb, wr_data_stb, enable_out, drvsel_out, step_dir} === 6'b0,
              "R12 strobes and latches after reset",
              {2'b0, rdata_valid, cmd_stb, wr_data_stb, enable_out, drvsel_out, step_dir}, 8'h00);
        rst = 0;
        @(negedge clk);

        // R2: data register keep and clear
        acc(0, 4'h0, 0, 1, 8'h00, "R2 data after reset");
        load_byte(8'h35);
        acc(0, 4'h0, 0, 1, 8'h35, "R2 data bit7 clear");
        acc(0, 4'h0, 0, 1, 8'h35, "R2 data kept");
        load_byte(8'hA5);
        acc(0, 4'h0, 0, 1, 8'hA5, "R2 data bit7 set");
        acc(0, 4'h0, 0, 1, 8'h00, "R2 data cleared");
        // R13: load wins over clearing read
        load_byte(8'h9C);
        acc(0, 4'h0, 0, 1, 8'h9C, "R13 old byte returned", 1'b1, 8'h81);
        acc(0, 4'h0, 0, 1, 8'h81, "R13 loaded byte kept");
        acc(0, 4'h0, 0, 1, 8'h00, "R13 cleared afterwards");

        // R6: odd read
        acc(0, 4'h1, 0, 1, 8'hFF, "R6 odd read");
        acc(1, 4'h0, 0, 0, 0, "");

        // R1: enable and drive select latches
        acc(1, 4'h9, 0, 0, 0, "");
        check(enable_out === 1'b1, "R1 enable set", {7'd0, enable_out}, 8'h01);
        acc(0, 4'hB, 0, 1, 8'hFF, "R6 odd read drive select");
        check(drvsel_out === 1'b1, "R1 drive select set by read", {7'd0, drvsel_out}, 8'h01);
        acc(1, 4'h8, 0, 0, 0, "");
        acc(1, 4'hA, 0, 0, 0, "");
        check({enable_out, drvsel_out} === 2'b00, "R1 latches cleared",
              {6'd0, enable_out, drvsel_out}, 8'h00);

        // R7: mode write with Q7,Q6 set, ENABLE clear
        acc(1, 4'hD, 8'h11, 0, 0, "");
        check(mode_out === 8'h00, "R9 write with Q6 only", mode_out, 8'h00);
        acc(1, 4'hF, 8'hEB, 0, 0, "");
        check(mode_out === 8'hEB, "R7 mode load", mode_out, 8'hEB);
        acc(0, 4'h6, 0, 1, 8'hFF, "R6 even read with Q6 Q7 set");
        // R8: write data with ENABLE set
        acc(1, 4'h9, 8'h5A, 0, 0, "");
        check(wr_data_stb === 1'b1 && wr_data_out === 8'h5A, "R8 write data strobe", wr_data_out, 8'h5A);
        check(mode_out === 8'hEB, "R8 mode unchanged", mode_out, 8'hEB);
        acc(1, 4'h8, 8'h00, 0, 0, "");
        check(mode_out === 8'h00, "R7 mode reload zero", mode_out, 8'h00);
        acc(1, 4'hF, 8'h1B, 0, 0, "");
        // R9: Q6 cleared, write ignored
        acc(1, 4'hC, 8'h77, 0, 0, "");
        check(mode_out === 8'h1B, "R9 write with Q7 only", mode_out, 8'h1B);
        // R5: handshake
        acc(0, 4'h6, 0, 1, 8'hFF, "R5 handshake read");
        check(mode_out === 8'h1B, "R9 read leaves mode", mode_out, 8'h1B);

        // R3/R4: status sweep
        acc(1, 4'hE, 0, 0, 0, "");
        acc(1, 4'hD, 0, 0, 0, "");
        for (int p = 0; p < 3; p++) begin
            {c_disk, c_wprot, c_mot, c_trk0, c_tach, c_one, c_pres} =
                (p == 0) ? 7'h7F : (p == 1) ? 7'h00 : 7'h55;
            motor_on_in = p[0];
            for (int c = 0; c < 16; c++) begin
                sel_in = c[0];
                acc(1, {3'd0, c[1]}, 0, 0, 0, "");
                acc(1, {3'd1, c[2]}, 0, 0, 0, "");
                acc(1, {3'd2, c[3]}, 0, 0, 0, "");
                acc(0, 4'h6, 0, 2, 0, "R4 R3 status sense");
            end
        end
        sel_in = 0;

        // R10/R11: strobe commands
        acc(1, 4'h0, 0, 0, 0, "");
        acc(1, 4'h2, 0, 0, 0, "");
        acc(1, 4'h5, 0, 0, 0, "");   // CA2 = 1
        acc(1, 4'h7, 0, 0, 0, "");   // rise: no command (R11)
        acc(1, 4'h6, 0, 0, 0, "");   // fall, code 000
        check(step_dir === 1'b1, "R10 step direction from CA2", {7'd0, step_dir}, 8'h01);
        acc(1, 4'h6, 0, 0, 0, "");   // no change: no command (R11)
        acc(1, 4'h1, 0, 0, 0, "");
        acc(1, 4'h7, 0, 0, 0, "");
        acc(1, 4'h6, 0, 0, 0, "");   // step
        acc(1, 4'h0, 0, 0, 0, "");
        acc(1, 4'h3, 0, 0, 0, "");
        acc(1, 4'h7, 0, 0, 0, "");
        acc(0, 4'h6, 0, 2, 0, "R10 status during motor command"); // motor on
        acc(1, 4'h1, 0, 0, 0, "");
        acc(1, 4'h7, 0, 0, 0, "");
        acc(1, 4'h6, 0, 0, 0, "");   // eject
        sel_in = 1;
        acc(1, 4'h7, 0, 0, 0, "");
        acc(1, 4'h6, 0, 0, 0, "");   // code 111: no command (R11)
        sel_in = 0;
        acc(1, 4'h0, 0, 0, 0, "");
        acc(1, 4'h2, 0, 0, 0, "");
        acc(1, 4'h4, 0, 0, 0, "");
        acc(1, 4'h7, 0, 0, 0, "");
        acc(1, 4'h6, 0, 0, 0, "");   // direction, CA2 = 0
        check(step_dir === 1'b0, "R10 step direction cleared", {7'd0, step_dir}, 8'h00);

        repeat (4) @(negedge clk);
        check(rq_exp.size() == 0, "R2 all reads returned", 8'(rq_exp.size()), 8'h00);
        check(cq_exp.size() == 0, "R10 all commands seen", 8'(cq_exp.size()), 8'h00);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule